// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor that executes one instruction per rising clock edge. It supports register-to-register add, subtract, AND, OR and signed set-less-than, word loads and stores, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry by 32-bit register file, an ALU, a sign extender, a branch target adder and the operand and write-back selectors. A main opcode decoder and a separate ALU function decoder steer them.

Instruction and data storage are small word-indexed arrays inside the block. A load port writes either array while the core is paused. A peek port reads one data word combinationally. The `run` input is the clock enable for every architectural update. When it is low, the program counter, the register file and data storage keep their values.

Instruction encoding uses opcode bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11, funct bits 5:0, a 16-bit immediate in bits 15:0 and a 26-bit jump field in bits 25:0. Word k of either array sits at byte address 4k.

Top module: `rc32_core`

## Requirements
- R1: While `rst_n` is low, `pc_out` is 0. It stays 0 until the first edge with `run` high after release.
- R2: On every edge with `run` high, an add, sub, and, or, slt, lw or sw instruction advances `pc_out` by 4. With `run` low, `pc_out` and all stored state hold.
- R3: An instruction with opcode 0x00 writes register rd (bits 15:11) with rs op rt. The funct values are add=0x20, sub=0x22, and=0x24, or=0x25 and slt=0x2A. The slt result is 1 when rs is less than rt as signed numbers, and 0 otherwise.
- R4: A load (opcode 0x23) writes register rt (bits 20:16) with the data word at byte address rs + sign-extended imm16.
- R5: A store (opcode 0x2B) writes the value of rt to the data word at byte address rs + sign-extended imm16.
- R6: Branch-if-equal (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next PC is PC+4 + (sign-extended imm16 << 2), and negative offsets are allowed. When they differ, the next PC is PC+4.
- R7: Jump (opcode 0x02) sets the next PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode writes no register and no data word, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| run | input | 1 | Clock enable for PC, register file and data stores |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load-port target: 0 = instruction array, 1 = data array |
| ld_addr | input | 6 | Load-port word index |
| ld_data | input | 32 | Load-port write word |
| peek_addr | input | 6 | Data-array word index for the peek port |
| peek_data | output | 32 | Data word at `peek_addr` |
| pc_out | output | 32 | Current program counter |

## Verification
The bound checker watches the following on every cycle:
- PC hold while paused and word alignment.
- The PC+4 step for sequential opcodes.
- The branch and jump target arithmetic.
- Zero reads of register 0.
- The absence of write enables for unknown opcodes.

Some results only show up as stored values, and only the bench's directed programs can expose them. These are the ALU results of each funct code, signed compare, negative load/store offsets, discarded writes to register 0 and skipped instructions. The bench reads them back through the peek port and checks cycle-exact PC values around taken and untaken branches.

// File: rtl/rc32_pkg.sv
package rc32_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  typedef enum logic [2:0] {
    ALU_AND,
    ALU_OR,
    ALU_ADD,
    ALU_SUB,
    ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic   dst_rd;     // write-back register from rd field, else rt
    logic   src_imm;    // second ALU operand is sign-extended immediate
    logic   wb_mem;     // write-back from data array, else ALU
    logic   reg_we;
    logic   mem_rd;
    logic   mem_we;
    logic   is_branch;
    logic   is_jump;
    aluop_e aluop;
  } ctrl_t;
endpackage

// File: rtl/rc32_ctrl.sv
module rc32_ctrl
  import rc32_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);
  // first level: opcode only
  always_comb begin
    ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
             mem_rd: 1'b0, mem_we: 1'b0, is_branch: 1'b0, is_jump: 1'b0,
             aluop: AOP_ADD};
    unique case (op)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.aluop  = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.aluop     = AOP_SUB;
      end
      OP_J: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end

  // second level: ALUOp plus funct
  always_comb begin
    unique case (ctrl.aluop)
      AOP_SUB:   alu_fn = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default:   alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/rc32_regfile.sv
module rc32_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);
  localparam int RAW = $clog2(NREG);

  logic [W-1:0] regs [NREG];
  logic         wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == RAW'(0)) ? '0 : regs[ra1];
  assign rd2 = (ra2 == RAW'(0)) ? '0 : regs[ra2];
endmodule

// File: rtl/rc32_alu.sv
module rc32_alu
  import rc32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rc32_core.sv
module rc32_core
  import rc32_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [DAW-1:0]  peek_addr,
  output logic [XLEN-1:0] peek_data,
  output logic [XLEN-1:0] pc_out
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rsync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  logic step;
  assign step = run && rst_q_n;

  // fetch
  logic [XLEN-1:0] pc, pc_nxt, pc4;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] instr;

  assign instr = imem[pc[IAW+1:2]];
  assign pc4   = pc + XLEN'(4);

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  // decode
  logic [5:0]  op, funct;
  logic [4:0]  rs_addr, rt_addr, rd_addr, wr_addr;
  logic [15:0] imm16;
  logic [25:0] jfield;
  ctrl_t       ctrl;
  alu_fn_e     alu_fn;

  assign op      = instr[31:26];
  assign rs_addr = instr[25:21];
  assign rt_addr = instr[20:16];
  assign rd_addr = instr[15:11];
  assign funct   = instr[5:0];
  assign imm16   = instr[15:0];
  assign jfield  = instr[25:0];

  rc32_ctrl u_ctrl (
    .op     (op),
    .funct  (funct),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  // operands
  logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, wb_val, dmem_rd;
  logic            alu_zero, rf_we;

  assign imm_sx  = {{(XLEN-16){imm16[15]}}, imm16};
  assign wr_addr = ctrl.dst_rd ? rd_addr : rt_addr;
  assign rf_we   = step && ctrl.reg_we;

  rc32_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (wr_addr),
    .wdata (wb_val),
    .ra1   (rs_addr),
    .ra2   (rt_addr),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_val;

  rc32_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data array
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [DAW-1:0]  d_idx;

  assign d_idx   = alu_y[DAW+1:2];
  assign dmem_rd = ctrl.mem_rd ? dmem[d_idx] : '0;

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel)             dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (step && ctrl.mem_we)    dmem[d_idx] <= rt_val;
  end

  assign peek_data = dmem[peek_addr];
  assign wb_val    = ctrl.wb_mem ? dmem_rd : alu_y;

  // next PC
  logic [XLEN-1:0] br_tgt, j_tgt;
  logic            take_br;

  assign br_tgt  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_tgt   = {pc4[31:28], jfield, 2'b00};
  assign take_br = ctrl.is_branch && alu_zero;

  always_comb begin
    if (ctrl.is_jump)  pc_nxt = j_tgt;
    else if (take_br)  pc_nxt = br_tgt;
    else               pc_nxt = pc4;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  pc <= '0;
    else if (step) pc <= pc_nxt;
  end

  assign pc_out = pc;

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], pc[XLEN-1:IAW+2], alu_y[1:0], alu_y[XLEN-1:DAW+2],
                         ld_addr, imm_sx[XLEN-1:XLEN-2]};
endmodule

// File: rtl/rc32_chk.sv
module rc32_chk
  import rc32_pkg::*;
(
  input logic            clk,
  input logic            rst_q_n,
  input logic            run,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [4:0]      rs_addr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rf_we,
  input logic            mem_we
);
  logic seq_op, known_op;
  assign seq_op   = (instr[31:26] == OP_RTYPE) || (instr[31:26] == OP_LW) ||
                    (instr[31:26] == OP_SW);
  assign known_op = seq_op || (instr[31:26] == OP_BEQ) || (instr[31:26] == OP_J);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !run |=> $stable(pc)); // R2

  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_q_n)
    pc[1:0] == 2'b00); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run && seq_op) |=> pc == $past(pc) + 32'd4); // R2

  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run && instr[31:26] == OP_BEQ && rs_val == rt_val) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R6

  AST_BR_NOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run && instr[31:26] == OP_BEQ && rs_val != rt_val) |=> pc == $past(pc) + 32'd4); // R6

  AST_JUMP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run && instr[31:26] == OP_J) |=>
      pc == {$past(pc[31:28] + ((pc[27:2] == 26'h3FFFFFF) ? 4'd1 : 4'd0)),
             $past(instr[25:0]), 2'b00}); // R7

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    rs_addr == 5'd0 |-> rs_val == '0); // R8

  AST_UNK_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !known_op |-> (!rf_we && !mem_we)); // R9

  AST_UNK_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (run && !known_op) |=> pc == $past(pc) + 32'd4); // R9
endmodule

bind rc32_core rc32_chk u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .run     (run),
  .pc      (pc),
  .instr   (instr),
  .rs_addr (rs_addr),
  .rs_val  (rs_val),
  .rt_val  (rt_val),
  .rf_we   (ctrl.reg_we),
  .mem_we  (ctrl.mem_we)
);

// File: tb/sim_rc32_core.sv
`timescale 1ns/1ps
module sim_rc32_core;
  logic        clk = 1'b0;
  logic        rst_n, run, ld_en, ld_sel;
  logic [5:0]  ld_addr, peek_addr;
  logic [31:0] ld_data, peek_data, pc_out;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  rc32_core u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_out(pc_out)
  );

  function automatic logic [31:0] rt_i(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_i(input int word);
    return {6'h02, 26'(word)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = 6'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int addr, output logic [31:0] v);
    @(negedge clk);
    peek_addr = 6'(addr);
    #1 v = peek_data;
  endtask

  task automatic go(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", pc_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pc after release", pc_out, 32'd0);
  endtask

  task automatic t_alu();
    logic [31:0] v;
    put(1, 0, 32'd7); put(1, 1, 32'hFFFF_FFFD);
    for (int i = 4; i < 10; i++) put(1, i, 32'hDEAD_0000);
    put(0, 0, it_i(6'h23, 0, 1, 0));
    put(0, 1, it_i(6'h23, 0, 2, 4));
    put(0, 2, rt_i(1, 2, 3, 6'h20));
    put(0, 3, rt_i(1, 2, 4, 6'h22));
    put(0, 4, rt_i(1, 2, 5, 6'h24));
    put(0, 5, rt_i(1, 2, 6, 6'h25));
    put(0, 6, rt_i(2, 1, 7, 6'h2A));
    put(0, 7, rt_i(1, 2, 8, 6'h2A));
    for (int i = 0; i < 6; i++) put(0, 8 + i, it_i(6'h2B, 0, 3 + i, 16 + 4 * i));
    put(0, 14, j_i(14));
    do_reset();
    go(3);
    chk("R2 pc after three steps", pc_out, 32'd12);
    repeat (3) @(negedge clk);
    chk("R2 pc held with run low", pc_out, 32'd12);
    go(17);
    chk("R7 self jump pc", pc_out, 32'd56);
    peek(4, v); chk("R3 add", v, 32'd4);
    peek(5, v); chk("R3 sub", v, 32'd10);
    peek(6, v); chk("R3 and", v, 32'd5);
    peek(7, v); chk("R3 or",  v, 32'hFFFF_FFFF);
    peek(8, v); chk("R3 slt signed true", v, 32'd1);
    peek(9, v); chk("R3 slt signed false / R4 lw", v, 32'd0);
  endtask

  task automatic t_mem();
    logic [31:0] v;
    put(1, 10, 32'd48); put(1, 11, 32'd0);
    put(0, 0, it_i(6'h23, 0, 1, 40));
    put(0, 1, it_i(6'h23, 1, 2, -8));
    put(0, 2, it_i(6'h2B, 1, 2, -4));
    put(0, 3, j_i(3));
    do_reset();
    go(6);
    peek(11, v); chk("R4 R5 negative offsets", v, 32'd48);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    put(1, 0, 32'd7); put(1, 1, 32'hFFFF_FFFD);
    put(1, 12, 32'd0); put(1, 13, 32'd0); put(1, 14, 32'd0);
    put(0, 0, it_i(6'h23, 0, 1, 0));
    put(0, 1, it_i(6'h23, 0, 2, 0));
    put(0, 2, it_i(6'h23, 0, 3, 4));
    put(0, 3, it_i(6'h04, 1, 3, 5));
    put(0, 4, it_i(6'h04, 1, 2, 2));
    put(0, 5, it_i(6'h2B, 0, 1, 48));
    put(0, 6, it_i(6'h2B, 0, 1, 52));
    put(0, 7, it_i(6'h2B, 0, 3, 56));
    put(0, 8, it_i(6'h04, 0, 0, -1));
    do_reset();
    go(4);
    chk("R6 untaken branch", pc_out, 32'd16);
    go(1);
    chk("R6 taken branch", pc_out, 32'd28);
    go(5);
    chk("R6 backward self branch", pc_out, 32'd32);
    peek(12, v); chk("R6 skipped store a", v, 32'd0);
    peek(13, v); chk("R6 skipped store b", v, 32'd0);
    peek(14, v); chk("R6 store at target", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_jump();
    logic [31:0] v;
    put(1, 15, 32'd0); put(1, 16, 32'd0); put(1, 17, 32'd0);
    put(0, 0, it_i(6'h23, 0, 1, 0));
    put(0, 1, j_i(4));
    put(0, 2, it_i(6'h2B, 0, 1, 60));
    put(0, 3, it_i(6'h2B, 0, 1, 64));
    put(0, 4, it_i(6'h2B, 0, 1, 68));
    put(0, 5, j_i(5));
    do_reset();
    go(2);
    chk("R7 jump target", pc_out, 32'd16);
    go(3);
    peek(15, v); chk("R7 skipped a", v, 32'd0);
    peek(16, v); chk("R7 skipped b", v, 32'd0);
    peek(17, v); chk("R7 store after jump", v, 32'd7);
  endtask

  task automatic t_r0();
    logic [31:0] v;
    put(1, 18, 32'h5555_5555); put(1, 19, 32'h5555_5555);
    put(0, 0, it_i(6'h23, 0, 1, 0));
    put(0, 1, it_i(6'h23, 0, 0, 0));
    put(0, 2, rt_i(1, 1, 0, 6'h20));
    put(0, 3, it_i(6'h2B, 0, 0, 72));
    put(0, 4, rt_i(0, 0, 5, 6'h25));
    put(0, 5, it_i(6'h2B, 0, 5, 76));
    put(0, 6, j_i(6));
    do_reset();
    go(8);
    peek(18, v); chk("R8 r0 after writes", v, 32'd0);
    peek(19, v); chk("R8 r0 as operand", v, 32'd0);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    put(1, 20, 32'h0000_1234); put(1, 21, 32'd0);
    put(0, 0, it_i(6'h23, 0, 1, 0));
    put(0, 1, it_i(6'h3F, 0, 1, 80));
    put(0, 2, it_i(6'h2B, 0, 1, 84));
    put(0, 3, j_i(3));
    do_reset();
    go(2);
    chk("R9 unknown op pc step", pc_out, 32'd8);
    go(3);
    peek(20, v); chk("R9 no data write", v, 32'h0000_1234);
    peek(21, v); chk("R9 no register write", v, 32'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; ld_en = 1'b0; ld_sel = 1'b0;
    ld_addr = '0; ld_data = '0; peek_addr = '0;
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_r0();
    t_unknown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule